// File: doc/BRIEF.md
# Dual-Direction Latched Bus Transceiver

This block connects an A-side bus and a B-side bus through two banks of data-holding stages, one for each direction of flow. The data lanes are grouped into sections (two sections of eight lanes by default). Each section has six active-low controls of its own, and the sections never affect each other. In each direction of a section, a select input gates both capture and drive. A hold input makes the stage follow its input while low and freeze on its release. A drive input enables the far-side port.

Tri-state pins are represented as a data vector plus a per-section drive-enable, so the core stays synthesizable. The pad ring combines the two into real bidirectional pins.

Storage is kept in clocked registers rather than level-sensitive latches. While a stage is open, its output follows the input with no register in the path, and the stored copy is refreshed on every rising clock edge. When the stage closes, it holds the input value taken at the last clock edge before closing. In each section, a flag reports any moment when both directions would drive at once.

Top module: `dual_latch_xcvr`

## Requirements
- R1: During and directly after reset, all stored lane values are zero. With every control high, both data outputs read zero, all drive-enables are low and all contention flags are low.
- R2: For section s, the A-to-B stage is open when its select (`ab_sel_n[s]`) and its hold (`ab_hold_n[s]`) are both low. While it is open, `b_dout[s*SEC_W +: SEC_W]` equals `a_din[s*SEC_W +: SEC_W]` in the same cycle, with no clock delay.
- R3: `b_drive[s]` is high exactly when `ab_sel_n[s]` and `ab_drv_n[s]` are both low.
- R4: While `ab_sel_n[s]` is high, `b_drive[s]` is low and the A-to-B stage stores. Changes on that section's A lanes do not reach `b_dout`, whatever the hold and drive inputs are set to.
- R5: While `ab_drv_n[s]` is high, `b_drive[s]` is low. If the select is low, the stage still opens and closes with its hold input, and `b_dout` still shows the stage contents.
- R6: When an open A-to-B stage closes, it keeps the A lane value sampled at the last rising clock edge before closing. Later changes on A do not alter `b_dout` while the stage stays closed.
- R7: The B-to-A direction follows R2 to R6 with `ba_sel_n`, `ba_hold_n` and `ba_drv_n`. It takes its data from `b_din` and produces `a_dout` and `a_drive`.
- R8: Section s uses data bits `[s*SEC_W +: SEC_W]` and control bit s only. Activity in one section never changes another section's outputs.
- R9: `clash[s]` is high exactly when `a_drive[s]` and `b_drive[s]` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that refreshes the stored lane values |
| rst_n | input | 1 | Asynchronous active-low reset; clears storage |
| a_din | input | NUM_SEC*SEC_W | Data arriving from the A pins |
| b_din | input | NUM_SEC*SEC_W | Data arriving from the B pins |
| ab_sel_n | input | NUM_SEC | A-to-B select, active low, one per section |
| ab_hold_n | input | NUM_SEC | A-to-B hold, active low: low follows, rising freezes |
| ab_drv_n | input | NUM_SEC | A-to-B drive enable for the B pins, active low |
| ba_sel_n | input | NUM_SEC | B-to-A select, active low |
| ba_hold_n | input | NUM_SEC | B-to-A hold, active low |
| ba_drv_n | input | NUM_SEC | B-to-A drive enable for the A pins, active low |
| b_dout | output | NUM_SEC*SEC_W | Data offered to the B pins |
| b_drive | output | NUM_SEC | Per-section enable of the B pin drivers |
| a_dout | output | NUM_SEC*SEC_W | Data offered to the A pins |
| a_drive | output | NUM_SEC | Per-section enable of the A pin drivers |
| clash | output | NUM_SEC | Per-section flag: both directions driving |

## Verification
A stored lane value that is wrong stays hidden while its stage is open, because the output then passes the live input. It shows on the data output as soon as the stage closes, in the same cycle as the release. For this reason, each capture test changes the input right after the close and compares the output again. A wrong select or drive decode shows at once on the drive-enable of that section. A leak between sections appears as a change in a section that was left idle, and the section tests look for that.

// File: rtl/dlx_pkg.sv
package dlx_pkg;

  // A stage passes its input through only while select and hold are both low.
  function automatic logic stage_open(input logic sel_n, input logic hold_n);
    return (!sel_n) && (!hold_n);
  endfunction

  // The far-side pins are driven only while select and drive are both low.
  function automatic logic stage_drive(input logic sel_n, input logic drv_n);
    return (!sel_n) && (!drv_n);
  endfunction

endpackage

// File: rtl/dlx_path.sv
module dlx_path
  import dlx_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  input  logic             sel_n,
  input  logic             hold_n,
  input  logic             drv_n,
  output logic [WIDTH-1:0] dout,
  output logic             drive,
  output logic             is_open
);

  logic [WIDTH-1:0] held_q;
  logic             open_w;

  assign open_w = stage_open(sel_n, hold_n);

  // Stored copy is refreshed every edge while open; it freezes when closed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (open_w) begin
      held_q <= din;
    end
  end

  assign dout    = open_w ? din : held_q;
  assign drive   = stage_drive(sel_n, drv_n);
  assign is_open = open_w;

endmodule

// File: rtl/dlx_section.sv
module dlx_section #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_din,
  input  logic [WIDTH-1:0] b_din,
  input  logic             ab_sel_n,
  input  logic             ab_hold_n,
  input  logic             ab_drv_n,
  input  logic             ba_sel_n,
  input  logic             ba_hold_n,
  input  logic             ba_drv_n,
  output logic [WIDTH-1:0] b_dout,
  output logic             b_drive,
  output logic [WIDTH-1:0] a_dout,
  output logic             a_drive,
  output logic             ab_open,
  output logic             ba_open,
  output logic             clash
);

  dlx_path #(.WIDTH(WIDTH)) u_ab (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (a_din),
    .sel_n   (ab_sel_n),
    .hold_n  (ab_hold_n),
    .drv_n   (ab_drv_n),
    .dout    (b_dout),
    .drive   (b_drive),
    .is_open (ab_open)
  );

  dlx_path #(.WIDTH(WIDTH)) u_ba (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (b_din),
    .sel_n   (ba_sel_n),
    .hold_n  (ba_hold_n),
    .drv_n   (ba_drv_n),
    .dout    (a_dout),
    .drive   (a_drive),
    .is_open (ba_open)
  );

  assign clash = a_drive && b_drive;

endmodule

// File: rtl/dual_latch_xcvr.sv
module dual_latch_xcvr #(
  parameter int SEC_W   = 8,
  parameter int NUM_SEC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SEC*SEC_W-1:0] a_din,
  input  logic [NUM_SEC*SEC_W-1:0] b_din,
  input  logic [NUM_SEC-1:0]       ab_sel_n,
  input  logic [NUM_SEC-1:0]       ab_hold_n,
  input  logic [NUM_SEC-1:0]       ab_drv_n,
  input  logic [NUM_SEC-1:0]       ba_sel_n,
  input  logic [NUM_SEC-1:0]       ba_hold_n,
  input  logic [NUM_SEC-1:0]       ba_drv_n,
  output logic [NUM_SEC*SEC_W-1:0] b_dout,
  output logic [NUM_SEC-1:0]       b_drive,
  output logic [NUM_SEC*SEC_W-1:0] a_dout,
  output logic [NUM_SEC-1:0]       a_drive,
  output logic [NUM_SEC-1:0]       clash
);

  localparam int BUS_W = NUM_SEC * SEC_W;

  // Named internal events, brought out for the bound checker.
  logic [NUM_SEC-1:0] ab_open;
  logic [NUM_SEC-1:0] ba_open;

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    dlx_section #(.WIDTH(SEC_W)) u_sec (
      .clk       (clk),
      .rst_n     (rst_n),
      .a_din     (a_din[s*SEC_W +: SEC_W]),
      .b_din     (b_din[s*SEC_W +: SEC_W]),
      .ab_sel_n  (ab_sel_n[s]),
      .ab_hold_n (ab_hold_n[s]),
      .ab_drv_n  (ab_drv_n[s]),
      .ba_sel_n  (ba_sel_n[s]),
      .ba_hold_n (ba_hold_n[s]),
      .ba_drv_n  (ba_drv_n[s]),
      .b_dout    (b_dout[s*SEC_W +: SEC_W]),
      .b_drive   (b_drive[s]),
      .a_dout    (a_dout[s*SEC_W +: SEC_W]),
      .a_drive   (a_drive[s]),
      .ab_open   (ab_open[s]),
      .ba_open   (ba_open[s]),
      .clash     (clash[s])
    );
  end

  if (BUS_W != NUM_SEC * SEC_W) begin : g_bad_width
    initial $error("bus width mismatch");
  end

endmodule

// File: rtl/dual_latch_xcvr_chk.sv
module dual_latch_xcvr_chk #(
  parameter int SEC_W   = 8,
  parameter int NUM_SEC = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_SEC*SEC_W-1:0] a_din,
  input logic [NUM_SEC*SEC_W-1:0] b_din,
  input logic [NUM_SEC-1:0]       ab_sel_n,
  input logic [NUM_SEC-1:0]       ab_drv_n,
  input logic [NUM_SEC-1:0]       ba_sel_n,
  input logic [NUM_SEC-1:0]       ba_drv_n,
  input logic [NUM_SEC*SEC_W-1:0] b_dout,
  input logic [NUM_SEC-1:0]       b_drive,
  input logic [NUM_SEC*SEC_W-1:0] a_dout,
  input logic [NUM_SEC-1:0]       a_drive,
  input logic [NUM_SEC-1:0]       clash,
  input logic [NUM_SEC-1:0]       ab_open,
  input logic [NUM_SEC-1:0]       ba_open
);

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_chk
    // R2
    ab_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ab_open[s] |-> (b_dout[s*SEC_W +: SEC_W] == a_din[s*SEC_W +: SEC_W]));
    // R3
    ab_drive_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_sel_n[s] && !ab_drv_n[s]) |-> b_drive[s]);
    // R4
    ab_sel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ab_sel_n[s] |-> (!b_drive[s] && !ab_open[s]));
    // R5
    ab_drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ab_drv_n[s] |-> !b_drive[s]);
    // R6
    ab_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ab_open[s]) && !ab_open[s])
        |-> (b_dout[s*SEC_W +: SEC_W] == $past(a_din[s*SEC_W +: SEC_W])));
    // R6
    ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(ab_open[s]) && !ab_open[s])
        |-> $stable(b_dout[s*SEC_W +: SEC_W]));
    // R7
    ba_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ba_open[s] |-> (a_dout[s*SEC_W +: SEC_W] == b_din[s*SEC_W +: SEC_W]));
    // R7
    ba_sel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ba_sel_n[s] || ba_drv_n[s]) |-> !a_drive[s]);
    // R7
    ba_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ba_open[s]) && !ba_open[s])
        |-> (a_dout[s*SEC_W +: SEC_W] == $past(b_din[s*SEC_W +: SEC_W])));
    // R9
    clash_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_drive[s] && b_drive[s]) |-> clash[s]);
    // R9
    clash_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_drive[s] && b_drive[s]) |-> !clash[s]);
  end

endmodule

bind dual_latch_xcvr dual_latch_xcvr_chk #(.SEC_W(SEC_W), .NUM_SEC(NUM_SEC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .a_din    (a_din),
  .b_din    (b_din),
  .ab_sel_n (ab_sel_n),
  .ab_drv_n (ab_drv_n),
  .ba_sel_n (ba_sel_n),
  .ba_drv_n (ba_drv_n),
  .b_dout   (b_dout),
  .b_drive  (b_drive),
  .a_dout   (a_dout),
  .a_drive  (a_drive),
  .clash    (clash),
  .ab_open  (ab_open),
  .ba_open  (ba_open)
);

// File: tb/tb_dual_latch_xcvr.sv
`timescale 1ns/1ps
module tb_dual_latch_xcvr;

  localparam int SW = 8;
  localparam int NS = 2;
  localparam int BW = SW * NS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [BW-1:0] a_din = '0;
  logic [BW-1:0] b_din = '0;
  logic [NS-1:0] ab_sel_n = '1, ab_hold_n = '1, ab_drv_n = '1;
  logic [NS-1:0] ba_sel_n = '1, ba_hold_n = '1, ba_drv_n = '1;
  logic [BW-1:0] b_dout, a_dout;
  logic [NS-1:0] b_drive, a_drive, clash;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dual_latch_xcvr #(.SEC_W(SW), .NUM_SEC(NS)) dut (
    .clk(clk), .rst_n(rst_n), .a_din(a_din), .b_din(b_din),
    .ab_sel_n(ab_sel_n), .ab_hold_n(ab_hold_n), .ab_drv_n(ab_drv_n),
    .ba_sel_n(ba_sel_n), .ba_hold_n(ba_hold_n), .ba_drv_n(ba_drv_n),
    .b_dout(b_dout), .b_drive(b_drive), .a_dout(a_dout),
    .a_drive(a_drive), .clash(clash)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [15:0] act, input logic [15:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  // Move to the next falling edge, apply nothing; callers then set inputs.
  task automatic fall();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic idle_all();
    fall();
    ab_sel_n = '1; ab_hold_n = '1; ab_drv_n = '1;
    ba_sel_n = '1; ba_hold_n = '1; ba_drv_n = '1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) fall();
    a_din = 16'hFFFF; b_din = 16'hFFFF;
    settle();
    chk_eq("R1 b_dout in reset", b_dout, 16'h0000);
    fall();
    rst_n = 1'b1;
    fall();
    settle();
    chk_eq("R1 b_dout", b_dout, 16'h0000);
    chk_eq("R1 a_dout", a_dout, 16'h0000);
    chk_eq("R1 drives", {12'h0, a_drive, b_drive}, 16'h0000);
    chk_eq("R1 clash", {14'h0, clash}, 16'h0000);
  endtask

  task automatic t_transparent();
    fall();
    ab_sel_n[0] = 1'b0; ab_hold_n[0] = 1'b0; ab_drv_n[0] = 1'b0;
    a_din = 16'h00A5;
    settle();
    chk_eq("R2 pass A5", {8'h0, b_dout[7:0]}, 16'h00A5);
    chk_eq("R3 drive on", {15'h0, b_drive[0]}, 16'h0001);
    for (int i = 0; i < 3; i++) begin
      fall();
      a_din[7:0] = 8'h3C ^ 8'(i * 17);
      settle();
      chk_eq("R2 pass pattern", {8'h0, b_dout[7:0]}, {8'h0, 8'h3C ^ 8'(i * 17)});
    end
  endtask

  task automatic t_capture();
    fall();
    a_din[7:0] = 8'h5A;
    ab_sel_n[0] = 1'b0; ab_hold_n[0] = 1'b0; ab_drv_n[0] = 1'b0;
    fall();
    ab_hold_n[0] = 1'b1;
    settle();
    chk_eq("R6 frozen at close", {8'h0, b_dout[7:0]}, 16'h005A);
    fall();
    a_din[7:0] = 8'hC3;
    settle();
    chk_eq("R6 ignores later A", {8'h0, b_dout[7:0]}, 16'h005A);
    chk_eq("R3 still driving", {15'h0, b_drive[0]}, 16'h0001);
  endtask

  task automatic t_sel_block();
    fall();
    ab_sel_n[0] = 1'b1; ab_hold_n[0] = 1'b0; ab_drv_n[0] = 1'b0;
    a_din[7:0] = 8'h11;
    settle();
    chk_eq("R4 drive off", {15'h0, b_drive[0]}, 16'h0000);
    chk_eq("R4 no pass", {8'h0, b_dout[7:0]}, 16'h005A);
    fall(); fall();
    ab_sel_n[0] = 1'b0; ab_hold_n[0] = 1'b1;
    settle();
    chk_eq("R4 nothing stored", {8'h0, b_dout[7:0]}, 16'h005A);
    chk_eq("R3 drive back", {15'h0, b_drive[0]}, 16'h0001);
  endtask

  task automatic t_drv_off();
    fall();
    ab_sel_n[0] = 1'b0; ab_hold_n[0] = 1'b0; ab_drv_n[0] = 1'b1;
    a_din[7:0] = 8'h77;
    settle();
    chk_eq("R5 drive off", {15'h0, b_drive[0]}, 16'h0000);
    chk_eq("R5 data follows", {8'h0, b_dout[7:0]}, 16'h0077);
    fall();
    ab_hold_n[0] = 1'b1;
    fall();
    a_din[7:0] = 8'h88;
    ab_drv_n[0] = 1'b0;
    settle();
    chk_eq("R5 captured while undriven", {8'h0, b_dout[7:0]}, 16'h0077);
    chk_eq("R5 drive returns", {15'h0, b_drive[0]}, 16'h0001);
  endtask

  task automatic t_reverse();
    idle_all();
    fall();
    ba_sel_n[0] = 1'b0; ba_hold_n[0] = 1'b0; ba_drv_n[0] = 1'b0;
    b_din[7:0] = 8'hE1;
    settle();
    chk_eq("R7 pass", {8'h0, a_dout[7:0]}, 16'h00E1);
    chk_eq("R7 drive", {15'h0, a_drive[0]}, 16'h0001);
    fall();
    ba_hold_n[0] = 1'b1;
    fall();
    b_din[7:0] = 8'h0F;
    settle();
    chk_eq("R7 capture", {8'h0, a_dout[7:0]}, 16'h00E1);
    fall();
    ba_drv_n[0] = 1'b1;
    settle();
    chk_eq("R7 drive off", {15'h0, a_drive[0]}, 16'h0000);
    chk_eq("R8 B path unaffected", {8'h0, b_dout[7:0]}, 16'h0077);
  endtask

  task automatic t_sections();
    idle_all();
    fall();
    ab_sel_n[1] = 1'b0; ab_hold_n[1] = 1'b0; ab_drv_n[1] = 1'b0;
    a_din = 16'h9C44;
    settle();
    chk_eq("R8 upper passes", {8'h0, b_dout[15:8]}, 16'h009C);
    chk_eq("R8 lower held", {8'h0, b_dout[7:0]}, 16'h0077);
    chk_eq("R8 drive only upper", {14'h0, b_drive}, 16'h0002);
    fall();
    ab_hold_n[1] = 1'b1;
    fall();
    a_din = 16'h2266;
    settle();
    chk_eq("R8 upper captured", {8'h0, b_dout[15:8]}, 16'h009C);
    chk_eq("R8 lower still held", {8'h0, b_dout[7:0]}, 16'h0077);
  endtask

  task automatic t_clash();
    idle_all();
    fall();
    ab_sel_n[1] = 1'b0; ab_drv_n[1] = 1'b0;
    settle();
    chk_eq("R9 one side no flag", {14'h0, clash}, 16'h0000);
    fall();
    ba_sel_n[1] = 1'b0; ba_drv_n[1] = 1'b0;
    settle();
    chk_eq("R9 flag on both", {14'h0, clash}, 16'h0002);
    idle_all();
    settle();
    chk_eq("R9 flag clears", {14'h0, clash}, 16'h0000);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_transparent();
        t_capture();
        t_sel_block();
        t_drv_off();
        t_reverse();
        t_sections();
        t_clash();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++;
          fails++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule